// File: doc/BRIEF.md
# Receive Frame Buffer Formatter

This block takes one incoming Ethernet frame at a time and lays it out inside a 2 KB packet page of a shared buffer memory. A frame is announced by a one-cycle start pulse that carries its length in bytes. The block then decides in that same cycle whether the frame is accepted. If it is, it claims the lowest free page from an external allocator and stores the frame through a byte-wide write port, one byte per cycle.

The stored image has four parts. It opens with a 4-byte header holding a status word and a byte count. The frame body follows at offset 4, with zero fill for short frames and an optional CRC-32. The image closes with a 2-byte tail that marks odd-length frames. The header is written last, from registers. When the image is complete, the page number is handed to the receive queue and the receive interrupt is raised for one cycle.

Frame bytes arrive on a valid/data pair and may have idle gaps between them. Software configuration enters as three level inputs: receive enable, soft reset and CRC strip.

Top module: `rxf_formatter`

## Requirements
- R1: After reset the block is idle (`idle`=1). It drives no write, no push and no allocation take until a frame is accepted.
- R2: A start pulse is dropped when `rx_enable` is 0 or `rx_soft_reset` is 1. No page is taken and nothing is written or pushed, and bytes that follow are ignored.
- R3: A start pulse is also dropped when `alloc_free` is 0, or when the stored size exceeds 2048. A stored size of exactly 2048 is accepted.
- R4: The stored size is computed in four steps. Take the frame length rounded down to even, with a minimum of 64. Add 6, then add 4 more when `rx_strip_crc` is 0. The result is written little-endian at offsets 2 (low byte) and 3 (high byte).
- R5: The status word is written little-endian at offsets 0 and 1. Bit 11 (0x0800) is set when the length exceeds 1518. Bit 12 (0x1000) is set when the length is odd. All other bits are 0.
- R6: Frame bytes are written in arrival order from offset 4, one write in the cycle each valid byte is presented. For a frame of 64 bytes or more with odd length, the final byte is held back and not written in that cycle.
- R7: A frame shorter than 64 bytes has every byte written in place, including an odd last byte. It is then zero filled up to offset 67. Its tail is 0x00 then 0x40.
- R8: When `rx_strip_crc` is 0, four CRC bytes follow the data and padding, least significant byte first. The CRC is CRC-32 (reflected polynomial 0xEDB88320, all-ones start, final inversion) over the frame bytes and any zero fill.
- R9: For a frame of 64 bytes or more, the tail is the held odd byte followed by 0x60 when the length is odd, and 0x00 followed by 0x40 when it is even. The tail sits directly after the CRC, or after the data when the CRC is stripped.
- R10: Writes occur in a fixed sequence: data, zero fill, CRC, tail, then header offsets 0 to 3. In the cycle after the last header write, `push_valid` and `rcv_int_set` pulse for one cycle with the page on `push_page`. The block is idle the following cycle.
- R11: `alloc_take` is 1 only in the cycle of an accepted start pulse. The page on `alloc_page` in that cycle is used for every write and for the push of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enable from configuration |
| rx_soft_reset | input | 1 | Soft reset request from configuration |
| rx_strip_crc | input | 1 | 1: do not store the CRC |
| frm_start | input | 1 | Start of a frame, sampled only while idle |
| frm_len | input | LEN_W | Frame length in bytes, valid with `frm_start` |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| alloc_free | input | 1 | Allocator has a free page |
| alloc_page | input | PAGE_W | Lowest free page number |
| alloc_take | output | 1 | Claims `alloc_page` this cycle |
| wr_en | output | 1 | Buffer byte write strobe |
| wr_page | output | PAGE_W | Page being written |
| wr_addr | output | ADDR_W | Byte offset in the page |
| wr_data | output | 8 | Byte to write |
| push_valid | output | 1 | Push the page onto the receive queue |
| push_page | output | PAGE_W | Page pushed |
| rcv_int_set | output | 1 | Sets the receive interrupt bit |
| idle | output | 1 | Ready for a new start pulse |

## Verification
The assertions rely on three conditions at the inputs. `frm_start` is raised only while `idle` is 1. Exactly `frm_len` valid bytes follow an accepted start. `alloc_page` names a genuinely free page whenever `alloc_free` is 1. The stimulus meets these conditions by waiting for `idle` after each frame, presenting exactly the announced number of bytes, with or without gaps, and holding a fixed page number per frame. For dropped frames the bench still streams bytes, so that ignoring them is visible at the write port.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DATA  = 3'd1,
        PH_PAD   = 3'd2,
        PH_CRC   = 3'd3,
        PH_TRAIL = 3'd4,
        PH_HDR   = 3'd5,
        PH_PUSH  = 3'd6
    } phase_e;

    localparam int          HDR_BYTES   = 4;
    localparam int          OVERHEAD    = 6;
    localparam int          CRC_BYTES   = 4;
    localparam logic [7:0]  TAIL_ODD    = 8'h60;
    localparam logic [7:0]  TAIL_EVEN   = 8'h40;
    localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte #(
    parameter logic [31:0] POLY = 32'hEDB8_8320
) (
    input  logic [31:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);
    logic [31:0] stage [0:8];

    assign stage[0] = crc_i;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign stage[b+1] = (stage[b][0] ^ byte_i[b]) ? ((stage[b] >> 1) ^ POLY)
                                                      : (stage[b] >> 1);
    end

    assign crc_o = stage[8];
endmodule

// File: rtl/rxf_admit.sv
module rxf_admit #(
    parameter int LEN_W      = 12,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_STD    = 1518,
    parameter int PAGE_BYTES = 2048
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic             enable_i,
    input  logic             soft_reset_i,
    input  logic             strip_crc_i,
    input  logic             free_i,
    output logic             accept_o,
    output logic [15:0]      size_o,
    output logic [15:0]      status_o
);
    import rxf_pkg::*;

    localparam int SZ_W = LEN_W + 2;

    logic [SZ_W-1:0] base, full;
    logic            fits, too_long;

    always_comb begin
        if (len_i < LEN_W'(MIN_FRAME))
            base = SZ_W'(MIN_FRAME);
        else
            base = SZ_W'({len_i[LEN_W-1:1], 1'b0});
        full     = base + SZ_W'(OVERHEAD) + (strip_crc_i ? SZ_W'(0) : SZ_W'(CRC_BYTES));
        fits     = (full <= SZ_W'(PAGE_BYTES));
        too_long = (len_i > LEN_W'(MAX_STD));
        accept_o = enable_i && !soft_reset_i && fits && free_i;
        size_o   = 16'(full);
        status_o = {3'b000, len_i[0], too_long, 11'b0};
    end
endmodule

// File: rtl/rxf_formatter.sv
module rxf_formatter #(
    parameter int LEN_W     = 12,
    parameter int PAGE_W    = 2,
    parameter int ADDR_W    = 11,
    parameter int MIN_FRAME = 64,
    parameter int MAX_STD   = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              rx_soft_reset,
    input  logic              rx_strip_crc,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              alloc_free,
    input  logic [PAGE_W-1:0] alloc_page,
    output logic              alloc_take,
    output logic              wr_en,
    output logic [PAGE_W-1:0] wr_page,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              push_valid,
    output logic [PAGE_W-1:0] push_page,
    output logic              rcv_int_set,
    output logic              idle
);
    import rxf_pkg::*;

    localparam int PAGE_BYTES = 1 << ADDR_W;
    localparam int PAD_LAST   = HDR_BYTES + MIN_FRAME - 1;

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [PAGE_W-1:0] page;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic [7:0]        odd_byte;
        logic [31:0]       crc;
        logic [15:0]       size;
        logic [15:0]       status;
        logic              keep_crc;
        logic [1:0]        sub;
    } st_t;

    st_t q, d;

    logic        adm_accept;
    logic [15:0] adm_size, adm_status;
    logic [7:0]  crc_byte;
    logic [31:0] crc_next, crc_final;
    logic        is_short, is_last, tail_odd;

    rxf_admit #(
        .LEN_W     (LEN_W),
        .MIN_FRAME (MIN_FRAME),
        .MAX_STD   (MAX_STD),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_admit (
        .len_i       (frm_len),
        .enable_i    (rx_enable),
        .soft_reset_i(rx_soft_reset),
        .strip_crc_i (rx_strip_crc),
        .free_i      (alloc_free),
        .accept_o    (adm_accept),
        .size_o      (adm_size),
        .status_o    (adm_status)
    );

    rxf_crc_byte #(.POLY(CRC_POLY)) u_crc (
        .crc_i (q.crc),
        .byte_i(crc_byte),
        .crc_o (crc_next)
    );

    always_comb begin
        d           = q;
        alloc_take  = 1'b0;
        wr_en       = 1'b0;
        wr_addr     = q.addr;
        wr_data     = 8'h00;
        push_valid  = 1'b0;
        crc_byte    = 8'h00;
        crc_final   = ~q.crc;
        is_short    = (q.len < LEN_W'(MIN_FRAME));
        is_last     = (q.idx == q.len - LEN_W'(1));
        tail_odd    = q.len[0] && !is_short;

        case (q.ph)
            PH_IDLE: begin
                if (frm_start && adm_accept) begin
                    alloc_take = 1'b1;
                    d.page     = alloc_page;
                    d.len      = frm_len;
                    d.idx      = '0;
                    d.addr     = ADDR_W'(HDR_BYTES);
                    d.crc      = '1;
                    d.size     = adm_size;
                    d.status   = adm_status;
                    d.keep_crc = !rx_strip_crc;
                    d.sub      = '0;
                    d.ph       = (frm_len == '0) ? PH_PAD : PH_DATA;
                end
            end
            PH_DATA: begin
                crc_byte = in_data;
                if (in_valid) begin
                    d.crc = crc_next;
                    d.idx = q.idx + LEN_W'(1);
                    if (is_last && tail_odd) begin
                        d.odd_byte = in_data;
                    end else begin
                        wr_en   = 1'b1;
                        wr_data = in_data;
                        d.addr  = q.addr + ADDR_W'(1);
                    end
                    if (is_last) begin
                        if (is_short)
                            d.ph = PH_PAD;
                        else
                            d.ph = q.keep_crc ? PH_CRC : PH_TRAIL;
                    end
                end
            end
            PH_PAD: begin
                wr_en  = 1'b1;
                d.crc  = crc_next;
                d.addr = q.addr + ADDR_W'(1);
                if (q.addr == ADDR_W'(PAD_LAST))
                    d.ph = q.keep_crc ? PH_CRC : PH_TRAIL;
            end
            PH_CRC: begin
                wr_en   = 1'b1;
                wr_data = crc_final[{q.sub, 3'b000} +: 8];
                d.addr  = q.addr + ADDR_W'(1);
                d.sub   = q.sub + 2'd1;
                if (q.sub == 2'd3)
                    d.ph = PH_TRAIL;
            end
            PH_TRAIL: begin
                wr_en = 1'b1;
                if (q.sub == 2'd0) begin
                    wr_data = tail_odd ? q.odd_byte : 8'h00;
                    d.addr  = q.addr + ADDR_W'(1);
                    d.sub   = 2'd1;
                end else begin
                    wr_data = tail_odd ? TAIL_ODD : TAIL_EVEN;
                    d.sub   = 2'd0;
                    d.ph    = PH_HDR;
                end
            end
            PH_HDR: begin
                wr_en   = 1'b1;
                wr_addr = ADDR_W'(q.sub);
                case (q.sub)
                    2'd0:    wr_data = q.status[7:0];
                    2'd1:    wr_data = q.status[15:8];
                    2'd2:    wr_data = q.size[7:0];
                    default: wr_data = q.size[15:8];
                endcase
                d.sub = q.sub + 2'd1;
                if (q.sub == 2'd3)
                    d.ph = PH_PUSH;
            end
            PH_PUSH: begin
                push_valid = 1'b1;
                d.ph       = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign wr_page     = q.page;
    assign push_page   = q.page;
    assign rcv_int_set = push_valid;
    assign idle        = (q.ph == PH_IDLE);

    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_take |-> (rx_enable && !rx_soft_reset)); // R2
    AST_TAKE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_take |-> alloc_free); // R3
    AST_WR_IN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (16'(wr_addr) < q.size)); // R4
    AST_PUSH_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(wr_en && (wr_addr == ADDR_W'(3)))); // R10
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> $stable(wr_page)); // R11
endmodule

// File: tb/sim_rxf_formatter.sv
module sim_rxf_formatter;
    localparam int LEN_W  = 12;
    localparam int PAGE_W = 2;
    localparam int ADDR_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_enable = 1'b0, rx_soft_reset = 1'b0, rx_strip_crc = 1'b0;
    logic frm_start = 1'b0;
    logic [LEN_W-1:0] frm_len = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic alloc_free = 1'b0;
    logic [PAGE_W-1:0] alloc_page = '0;
    logic alloc_take, wr_en, push_valid, rcv_int_set, idle;
    logic [PAGE_W-1:0] wr_page, push_page;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0] wr_data;

    always #4 clk = ~clk;

    rxf_formatter #(.LEN_W(LEN_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_soft_reset(rx_soft_reset),
        .rx_strip_crc(rx_strip_crc), .frm_start(frm_start), .frm_len(frm_len),
        .in_valid(in_valid), .in_data(in_data), .alloc_free(alloc_free),
        .alloc_page(alloc_page), .alloc_take(alloc_take), .wr_en(wr_en),
        .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
        .push_valid(push_valid), .push_page(push_page), .rcv_int_set(rcv_int_set),
        .idle(idle)
    );

    typedef struct { bit is_push; int page; int addr; int data; } exp_t;
    exp_t expq[$];
    logic [7:0] fb [0:4095];
    int checks = 0, errors = 0, cyc = 0;
    bit fin = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !fin) begin
            fin = 1'b1;
            checks++; errors++;
            $display("FAIL R10 watchdog: actual %0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++)
            r = (r[0] ^ b[k]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic add_wr(int page, int addr, int data);
        exp_t e;
        e.is_push = 0; e.page = page; e.addr = addr; e.data = data;
        expq.push_back(e);
    endtask

    task automatic build(int len, bit strip, int page);
        int a = 4;
        int even = len & ~1;
        int size;
        int status;
        logic [31:0] crc = 32'hFFFFFFFF;
        exp_t e;
        for (int i = 0; i < len; i++) crc = crc_step(crc, fb[i]);
        for (int i = len; i < 64; i++) crc = crc_step(crc, 8'h00);
        crc = ~crc;
        if (len < 64) begin
            for (int i = 0; i < len; i++) begin add_wr(page, a, fb[i]); a++; end
            for (int i = len; i < 64; i++) begin add_wr(page, a, 0); a++; end
        end else begin
            for (int i = 0; i < even; i++) begin add_wr(page, a, fb[i]); a++; end
        end
        if (!strip)
            for (int k = 0; k < 4; k++) begin add_wr(page, a, (crc >> (8*k)) & 255); a++; end
        if (len >= 64 && (len & 1)) begin
            add_wr(page, a, fb[len-1]); add_wr(page, a+1, 'h60);
        end else begin
            add_wr(page, a, 0); add_wr(page, a+1, 'h40);
        end
        size = ((len < 64) ? 64 : even) + 6 + (strip ? 0 : 4);
        status = ((len > 1518) ? 'h0800 : 0) | ((len & 1) ? 'h1000 : 0);
        add_wr(page, 0, status & 255); add_wr(page, 1, status >> 8);
        add_wr(page, 2, size & 255);   add_wr(page, 3, size >> 8);
        e.is_push = 1; e.page = page; e.addr = 0; e.data = 0;
        expq.push_back(e);
    endtask

    task automatic cycle_check(string req);
        exp_t e;
        int act;
        if (wr_en) begin
            act = (int'(wr_page) << 20) | (int'(wr_addr) << 8) | int'(wr_data);
            if (expq.size() == 0 || expq[0].is_push)
                chk(0, req, "unexpected write", act, 0);
            else begin
                e = expq.pop_front();
                chk(act == ((e.page << 20) | (e.addr << 8) | e.data), req,
                    "write page/addr/data", act, (e.page << 20) | (e.addr << 8) | e.data);
            end
        end
        if (push_valid) begin
            if (expq.size() == 0 || !expq[0].is_push)
                chk(0, req, "unexpected push", int'(push_page), 0);
            else begin
                e = expq.pop_front();
                chk(int'(push_page) == e.page, req, "push page", int'(push_page), e.page);
                chk(rcv_int_set == 1'b1, req, "receive interrupt with push", rcv_int_set, 1);
            end
        end else if (rcv_int_set) begin
            chk(0, req, "interrupt without push", 1, 0);
        end
    endtask

    task automatic run_frame(int len, bit en, bit srst, bit strip, bit free,
                             int page, bit gap, string req);
        int sz = ((len < 64) ? 64 : (len & ~1)) + 6 + (strip ? 0 : 4);
        bit acc = en && !srst && free && (sz <= 2048);
        int i = 0;
        int n = 0;
        for (int k = 0; k < len; k++) fb[k] = 8'((k * 37 + len * 11 + 5) & 255);
        @(negedge clk);
        frm_start = 1'b1; frm_len = LEN_W'(len);
        rx_enable = en; rx_soft_reset = srst; rx_strip_crc = strip;
        alloc_free = free; alloc_page = PAGE_W'(page); in_valid = 1'b0;
        #3;
        chk(alloc_take == acc, acc ? "R11" : "R2 R3", "alloc_take on start", alloc_take, acc);
        chk(wr_en == 1'b0, "R11", "no write in start cycle", wr_en, 0);
        if (acc) build(len, strip, page);
        while (i < len) begin
            @(negedge clk);
            frm_start = 1'b0;
            in_valid  = !(gap && (n % 3 == 2));
            in_data   = fb[i];
            n++;
            #3;
            cycle_check(req);
            if (in_valid) i++;
        end
        @(negedge clk);
        frm_start = 1'b0; in_valid = 1'b0;
        #3;
        cycle_check(req);
        for (int t = 0; t < 200 && expq.size() > 0; t++) begin
            @(negedge clk); #3;
            cycle_check(req);
        end
        chk(expq.size() == 0, req, "all expected writes seen", expq.size(), 0);
        @(negedge clk); #3;
        chk(idle == 1'b1, req, "idle after frame", idle, 1);
        chk(wr_en == 1'b0 && push_valid == 1'b0, req, "quiet after frame",
            {wr_en, push_valid}, 0);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        chk(idle == 1'b1, "R1", "idle in reset", idle, 1);
        chk(wr_en == 1'b0, "R1", "no write in reset", wr_en, 0);
        chk(push_valid == 1'b0 && alloc_take == 1'b0, "R1", "no push/take in reset",
            {push_valid, alloc_take}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #3;
        chk(idle == 1'b1 && wr_en == 1'b0, "R1", "idle after reset", {idle, wr_en}, 2);

        run_frame(100,  1, 0, 0, 1, 2, 0, "R4 R5 R6 R8 R10");
        run_frame(65,   1, 0, 0, 1, 1, 1, "R5 R6 R8 R9");
        run_frame(33,   1, 0, 0, 1, 3, 0, "R7 R8");
        run_frame(20,   1, 0, 1, 1, 0, 1, "R7 R4");
        run_frame(64,   1, 0, 1, 1, 1, 0, "R6 R9");
        run_frame(1519, 1, 0, 1, 1, 2, 1, "R5 R9");
        run_frame(2042, 1, 0, 1, 1, 3, 0, "R3 R4");
        run_frame(2044, 1, 0, 0, 1, 0, 0, "R3");
        run_frame(80,   0, 0, 0, 1, 1, 0, "R2");
        run_frame(80,   1, 1, 0, 1, 1, 0, "R2");
        run_frame(90,   1, 0, 0, 0, 2, 1, "R3");
        run_frame(71,   1, 0, 0, 1, 2, 0, "R9 R10 R11");

        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule